// File: doc/BRIEF.md
# Watchdog Compare Timer

The block holds two independent watchdog channels, each reached through one 32-bit register word. A channel has an upward counter that advances once per 10 ms tick and a programmable expiry limit. When the count reaches the limit it stops there and the channel is expired. Software services a channel by writing its word. Every write clears the count and restarts that channel's tick interval.

Channel 0 can raise a one-cycle reset request when it expires. Channel 1 can instead hold a protective output that tells the switch fabric to discard traffic bound for the CPU and to stop flow control. The 10 ms tick is derived from the system clock by a per-channel prescaler. The ratio comes from the clock-frequency and tick-rate parameters. Whatever acts on the request and on the protective output sits outside the block.

Top module: `wdt_cmp_top`

## Requirements
- R1: After reset, both words read 0x7FFF0000: action bit 0, limit 0x7FFF, count 0. rst_req_o, drop_o and expired_o are all 0.
- R2: The count in bits 14:0 rises by one after every CLK_HZ/TICK_HZ clock cycles since the last write to that word. With the default parameters, that is one step per 10 ms.
- R3: A write to a word clears its count to 0 and restarts its tick interval. Bits 14:0 of the write data have no effect.
- R4: Bits 30:16 of the write data become the word's limit and read back unchanged. Bit 15 always reads 0, whatever was written there.
- R5: The count stops at the limit. expired_o[i] is 1 exactly while word i's count equals its limit, and it stays 1 until the next write to word i.
- R6: When bit 31 of word 0 is 1, rst_req_o is high for exactly one cycle: the cycle in which word 0's count first equals its limit after a write. When bit 31 is 0, rst_req_o stays low.
- R7: drop_o is 1 while bit 31 of word 1 is 1 and channel 1 is expired. It is 0 otherwise, including when channel 1 is expired with bit 31 at 0.
- R8: reg_sel = 0 selects word 0 and reg_sel = 1 selects word 1. A write to one word leaves the other word's count, limit and tick phase untouched.
- R9: A limit of 0 expires in the cycle right after the write. With bit 31 of word 0 set, the reset pulse falls in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for the selected word |
| reg_sel | input | 1 | Word select: 0 = reset channel, 1 = drop channel |
| reg_wdata | input | 32 | Write data: bit 31 action enable, bits 30:16 limit |
| reg_rdata | output | 32 | Selected word: action, limit, 0, count |
| rst_req_o | output | 1 | One-cycle reset request from channel 0 |
| drop_o | output | 1 | Discard CPU-bound traffic and disable flow control |
| expired_o | output | 2 | Per-channel expiry level |

## Verification
The bench sets CLK_HZ to 400 and keeps TICK_HZ at 100, so one tick lasts four clock cycles instead of a million. With ticks that short, limits between 0 and 10 reach saturation, the reset pulse and the protective output within a few dozen cycles. The exact cycle of each count step and of the expiry edge can then be predicted and checked. The default parameters are elaborated but cannot reach expiry within the bench's run.

// File: rtl/wdt_cmp_pkg.sv
package wdt_cmp_pkg;
  localparam int CNT_W  = 15;
  localparam int WORD_W = 32;
  localparam int NUM_CH = 2;
  localparam int SEL_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  // Register word layout: action[31], limit[30:16], zero[15], count[14:0]
  typedef struct packed {
    logic             act;
    logic [CNT_W-1:0] limit;
    logic             rsvd;
    logic [CNT_W-1:0] count;
  } wdt_word_t;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int TICK_CYCLES = 1000000
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);
  localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic          at_last;

  assign at_last = (pre_q == LAST);

  always_comb begin
    pre_d = pre_q + 1'b1;
    if (restart_i || at_last) pre_d = '0;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_d;
  end

  assign tick_o = at_last;

  AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_ni)
    pre_q <= LAST); // R2
endmodule

// File: rtl/wdt_channel.sv
module wdt_channel
  import wdt_cmp_pkg::*;
#(
  parameter int TICK_CYCLES = 1000000
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             wr_act_i,
  input  logic [CNT_W-1:0] wr_limit_i,
  output wdt_word_t        word_o,
  output logic             expired_o,
  output logic             first_hit_o
);
  logic             tick;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lim_q, lim_d;
  logic             act_q, act_d;
  logic             seen_q, seen_d;
  logic             match;

  wdt_prescaler #(.TICK_CYCLES(TICK_CYCLES)) u_pre (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .restart_i (wr_i),
    .tick_o    (tick)
  );

  assign match = (cnt_q == lim_q);

  always_comb begin
    cnt_d  = cnt_q;
    lim_d  = lim_q;
    act_d  = act_q;
    seen_d = match;
    if (wr_i) begin
      cnt_d  = '0;
      lim_d  = wr_limit_i;
      act_d  = wr_act_i;
      seen_d = 1'b0;
    end else if (tick && !match) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lim_q  <= '1;
      act_q  <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lim_q  <= lim_d;
      act_q  <= act_d;
      seen_q <= seen_d;
    end
  end

  assign word_o      = '{act: act_q, limit: lim_q, rsvd: 1'b0, count: cnt_q};
  assign expired_o   = match;
  assign first_hit_o = match && !seen_q;

  AST_CNT_LE_LIMIT: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q <= lim_q); // R5
  AST_WR_CLEARS: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_i |=> (cnt_q == '0)); // R3
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_ni)
    !wr_i |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1)); // R2
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (expired_o && !wr_i) |=> expired_o); // R5
endmodule

// File: rtl/wdt_cmp_top.sv
module wdt_cmp_top
  import wdt_cmp_pkg::*;
#(
  parameter int CLK_HZ  = 100000000,
  parameter int TICK_HZ = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              rst_req_o,
  output logic              drop_o,
  output logic [NUM_CH-1:0] expired_o
);
  localparam int TICK_CYCLES = (CLK_HZ / TICK_HZ > 1) ? CLK_HZ / TICK_HZ : 2;
  localparam int RST_CH  = 0;
  localparam int DROP_CH = 1;

  logic              rst_s_n;
  wdt_word_t         words [NUM_CH];
  logic [NUM_CH-1:0] first_hit;
  wdt_word_t         wr_word;
  logic              wdata_unused;

  wdt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  assign wr_word      = wdt_word_t'(reg_wdata);
  assign wdata_unused = ^{wr_word.rsvd, wr_word.count};

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    wdt_channel #(.TICK_CYCLES(TICK_CYCLES)) u_ch (
      .clk         (clk),
      .rst_ni      (rst_s_n),
      .wr_i        (reg_we && (reg_sel == SEL_W'(i))),
      .wr_act_i    (wr_word.act),
      .wr_limit_i  (wr_word.limit),
      .word_o      (words[i]),
      .expired_o   (expired_o[i]),
      .first_hit_o (first_hit[i])
    );
  end

  assign reg_rdata = words[reg_sel];
  assign rst_req_o = words[RST_CH].act && first_hit[RST_CH];
  assign drop_o    = words[DROP_CH].act && expired_o[DROP_CH];

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rst_req_o && !(reg_we && reg_sel == SEL_W'(RST_CH))) |=> !rst_req_o); // R6
  AST_DROP_HOLD: assert property (@(posedge clk) disable iff (!rst_s_n)
    (drop_o && !(reg_we && reg_sel == SEL_W'(DROP_CH))) |=> drop_o); // R7
endmodule

// File: tb/wdt_cmp_top_tb.sv
module wdt_cmp_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TC = 4;

  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [0:0]  reg_sel;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        rst_req_o;
  logic        drop_o;
  logic [1:0]  expired_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  wdt_cmp_top #(.CLK_HZ(400), .TICK_HZ(100)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .rst_req_o (rst_req_o),
    .drop_o    (drop_o),
    .expired_o (expired_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // {sel, wdata, wait cycles, expected read}
  localparam int NV = 6;
  localparam logic [80:0] VEC [NV] = '{
    {1'b0, 32'h0005_0000, 16'd9,  32'h0005_0002},  // R2
    {1'b0, 32'h0005_FFFF, 16'd0,  32'h0005_0000},  // R3 R4
    {1'b1, 32'h0003_0000, 16'd30, 32'h0003_0003},  // R5
    {1'b1, 32'h7FFF_0000, 16'd4,  32'h7FFF_0001},  // R2
    {1'b0, 32'h800A_0000, 16'd41, 32'h800A_000A},  // R2 R5
    {1'b0, 32'h0000_0000, 16'd3,  32'h0000_0000}   // R9
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // leaves the clock at the negedge just after the write edge
  task automatic do_write(input logic s, input logic [31:0] d);
    @(negedge clk);
    reg_sel   = s;
    reg_wdata = d;
    reg_we    = 1'b1;
    @(negedge clk);
    reg_we    = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    int pulses;
    rst_n = 1'b0; reg_we = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    reg_sel = 1'b0; #1;
    check("R1 word0", reg_rdata, 32'h7FFF_0000);
    reg_sel = 1'b1; #1;
    check("R1 word1", reg_rdata, 32'h7FFF_0000);
    check("R1 outputs", {28'd0, rst_req_o, drop_o, expired_o}, 32'd0);

    // vector table walk
    for (int v = 0; v < NV; v++) begin
      logic [31:0] er;
      do_write(VEC[v][80], VEC[v][79:48]);
      repeat (int'(VEC[v][47:32])) @(negedge clk);
      er = VEC[v][31:0];
      check($sformatf("R2/R3/R4 vec%0d read", v), reg_rdata, er);
      check($sformatf("R5 vec%0d expired", v), {31'd0, expired_o[VEC[v][80]]},
            {31'd0, er[30:16] == er[14:0]});
    end

    // R6 pulse timing, limit 3 => hit after 12 cycles
    pulses = 0;
    do_write(1'b0, 32'h8003_0000);
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      if (rst_req_o) pulses++;
      if (k == 11 || k == 12 || k == 13)
        check($sformatf("R6 pulse k=%0d", k), {31'd0, rst_req_o}, {31'd0, k == 12});
    end
    check("R6 pulse count", pulses, 1);

    // R6 disabled: no pulse
    pulses = 0;
    do_write(1'b0, 32'h0002_0000);
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (rst_req_o) pulses++;
    end
    check("R6 no pulse when disabled", pulses, 0);
    check("R5 expired while disabled", {31'd0, expired_o[0]}, 32'd1);

    // R7 drop output
    do_write(1'b1, 32'h8002_0000);
    repeat (7) @(negedge clk);
    check("R7 drop before expiry", {31'd0, drop_o}, 32'd0);
    @(negedge clk);
    check("R7 drop at expiry", {31'd0, drop_o}, 32'd1);
    repeat (12) @(negedge clk);
    check("R7 drop held", {31'd0, drop_o}, 32'd1);
    do_write(1'b1, 32'h0002_0000);
    repeat (10) @(negedge clk);
    check("R7 drop off when disabled", {31'd0, drop_o}, 32'd0);
    check("R7 channel1 expired", {31'd0, expired_o[1]}, 32'd1);

    // R8 independence
    do_write(1'b1, 32'h7FFF_0000);
    repeat (8) @(negedge clk);
    do_write(1'b0, 32'h7FFF_0000);
    reg_sel = 1'b1; #1;
    check("R8 word1 untouched", reg_rdata, 32'h7FFF_0002);
    reg_sel = 1'b0; #1;
    check("R8 word0 cleared", reg_rdata, 32'h7FFF_0000);

    // R9 zero limit
    do_write(1'b0, 32'h8000_0000);
    check("R9 pulse right after write", {31'd0, rst_req_o}, 32'd1);
    check("R9 expired", {31'd0, expired_o[0]}, 32'd1);
    @(negedge clk);
    check("R9 pulse ends", {31'd0, rst_req_o}, 32'd0);

    done = 1;
    summary();
    $finish;
  end
endmodule